// File: doc/BRIEF.md
# Resizable Byte-Lane DMA FIFO with Residual Count

This block buffers data between a host-side DMA engine and a SCSI-side byte mover. The host side writes one 32-bit dword per cycle with a byte enable per lane. The SCSI side pulls one byte per read request. Storage is four independent 8-bit lane memories of 134 rows each. Fill is tracked per byte, so a transfer may begin or end on any lane.

A size input selects a usable capacity of 88 bytes or 536 bytes. The size input only takes effect while the FIFO holds nothing. Neither capacity is a power of two, so both pointers wrap at the capacity of the current mode.

A byte offset counter advances by the number of bytes accepted. When a transfer halts, software subtracts the low bits of a byte-count value from this counter, masks the result according to the mode, and learns how many bytes are still held. The block performs that subtraction in hardware and presents the result as a residual output.

Top module: `dma_byte_fifo`

## Requirements
- R1: After `rst`, or one cycle after a `clr` pulse, `fill`=0, `empty`=1, `full`=0, `overflow`=0 and the offset is 0, so `ofs_lo`, `ofs_hi` and the residual (with `bcnt`=0) all read 0.
- R2: Bytes leave in the order they were accepted, lane 0 before lane 3 within a dword. Each accepted read request gives one byte on `rd_data` with `rd_valid`=1 in the following cycle.
- R3: A write's enabled lanes must be contiguous, and the lowest enabled lane must equal the count of bytes accepted since the pointers last restarted, modulo 4. Partial dwords are therefore accepted at the start and end of a transfer.
- R4: With `deep_sel`=0 in effect, capacity is 88 bytes, and `full`=1 exactly when `fill`=88.
- R5: With `deep_sel`=1 in effect, capacity is 536 bytes, and `full`=1 exactly when `fill`=536.
- R6: A write whose bytes do not all fit is dropped whole: no byte is stored and `fill` does not change. It sets `overflow`, which stays at 1 until `clr`.
- R7: A read request while empty is ignored: `rd_valid` stays 0 and `fill` stays 0.
- R8: A change of `deep_sel` takes effect only in a cycle where the FIFO is empty and no write is requested, and both pointers then restart at lane 0. While data is held, the old capacity remains in force.
- R9: The offset counter adds the number of bytes accepted. `ofs_lo` is offset bits 7:0 and `ofs_hi` is bits 9:8. In 88-byte mode the counter is 7 bits, so it wraps modulo 128 and `ofs_hi` and `ofs_lo[7]` read 0.
- R10: `residual` = (offset − `bcnt`) AND 7Fh in 88-byte mode, or AND 3FFh in 536-byte mode. It is registered and reflects the `bcnt` seen at the previous clock edge.
- R11: A write and a read accepted in the same cycle change `fill` by the written byte count minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of pointers, fill, offset and overflow |
| deep_sel | input | 1 | 0 selects 88-byte capacity, 1 selects 536-byte capacity |
| wr_en | input | 1 | Write request |
| wr_be | input | 4 | Byte enables, bit i selects lane i |
| wr_data | input | 32 | Write dword, lane i in bits 8i+7:8i |
| rd_en | input | 1 | Read one byte |
| rd_data | output | 8 | Byte read, valid when rd_valid is 1 |
| rd_valid | output | 1 | rd_data holds the byte of the previous accepted read |
| bcnt | input | 10 | Byte-count value subtracted for the residual |
| fill | output | 10 | Bytes currently held |
| empty | output | 1 | fill is 0 |
| full | output | 1 | fill equals the current capacity |
| overflow | output | 1 | Sticky flag for a rejected write |
| residual | output | 10 | Masked offset minus bcnt |
| ofs_lo | output | 8 | Offset counter bits 7:0 |
| ofs_hi | output | 2 | Offset counter bits 9:8 |

## Verification
Storage is exercised with three write patterns: whole aligned dwords, a run of partial dwords that walks the start lane through every position, and a write and a read in the same cycle. Together these separate lane ordering, pointer advance by the enable count, and the fill arithmetic. Both capacities are filled to the brim and pushed one write past it, which tells the 88-byte and 536-byte wrap points apart. A full-dword write into 2 free bytes shows that a write is dropped whole, not clipped. The residual is checked against several `bcnt` values, including one larger than the offset and one after the 7-bit counter has wrapped, so a wrong mask or a wrong borrow shows up as a wrong value.

// File: rtl/dma_fifo_pkg.sv
package dma_fifo_pkg;
  localparam int LANES = 4;

  typedef enum logic {
    SZ_SHALLOW = 1'b0,
    SZ_DEEP    = 1'b1
  } fifo_size_e;
endpackage

// File: rtl/byte_lane_ram.sv
module byte_lane_ram #(
  parameter int DEPTH = 134,
  parameter int AW    = 8,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // Write and registered read in one process, without reset, so a block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/fifo_ptr_ctrl.sv
module fifo_ptr_ctrl
  import dma_fifo_pkg::*;
#(
  parameter int SHALLOW_BYTES = 88,
  parameter int DEEP_BYTES    = 536,
  parameter int PTR_W         = 10,
  parameter int OFS_W         = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             deep_sel,
  input  logic             wr_en,
  input  logic [LANES-1:0] wr_be,
  input  logic             rd_en,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [LANES-1:0] lane_we,
  output logic             rd_fire,
  output logic [PTR_W-1:0] fill,
  output logic             empty,
  output logic             full,
  output logic             overflow,
  output logic             mode_q,
  output logic             mode_n,
  output logic [OFS_W-1:0] ofs_n
);
  localparam int NB_W = $clog2(LANES + 1);
  localparam logic [PTR_W-1:0] CAP_S = PTR_W'(SHALLOW_BYTES);
  localparam logic [PTR_W-1:0] CAP_D = PTR_W'(DEEP_BYTES);

  fifo_size_e       mode_r;
  logic [NB_W-1:0]  nb;
  logic [PTR_W-1:0] cap, cap_n, wr_step, wr_adv, rd_adv;
  logic [PTR_W-1:0] wr_ptr_n, rd_ptr_n, fill_n;
  logic [OFS_W-1:0] ofs_q;
  logic             wr_req, wr_fits, wr_fire, mode_sw, ovf_n;

  assign mode_q = (mode_r == SZ_DEEP);

  // Bytes offered by this write.
  always_comb begin
    nb = '0;
    for (int i = 0; i < LANES; i++) nb = nb + NB_W'(wr_be[i]);
  end

  assign cap     = mode_q ? CAP_D : CAP_S;
  assign wr_req  = wr_en & (|wr_be);
  assign wr_fits = ({1'b0, fill} + (PTR_W + 1)'(nb)) <= {1'b0, cap};
  assign wr_fire = wr_req & wr_fits & ~clr;
  assign rd_fire = rd_en & (fill != '0) & ~clr;

  // The size input is taken only with nothing held and no write in flight.
  assign mode_sw = ~clr & (fill == '0) & ~wr_req & (deep_sel != mode_q);
  assign mode_n  = mode_sw ? deep_sel : mode_q;
  assign cap_n   = mode_n ? CAP_D : CAP_S;

  assign wr_step = wr_fire ? PTR_W'(nb) : '0;
  assign wr_adv  = wr_ptr + wr_step;
  assign rd_adv  = rd_ptr + PTR_W'(1);
  assign lane_we = wr_fire ? wr_be : '0;

  always_comb begin
    if (clr || mode_sw) begin
      wr_ptr_n = '0;
      rd_ptr_n = '0;
    end else begin
      wr_ptr_n = (wr_adv == cap) ? '0 : wr_adv;
      rd_ptr_n = rd_fire ? ((rd_adv == cap) ? '0 : rd_adv) : rd_ptr;
    end
  end

  assign fill_n = clr ? '0 : (fill + wr_step - PTR_W'(rd_fire));
  assign ofs_n  = clr ? '0 : (ofs_q + (wr_fire ? OFS_W'(nb) : '0));
  assign ovf_n  = clr ? 1'b0 : (overflow | (wr_req & ~wr_fits));

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      fill     <= '0;
      ofs_q    <= '0;
      empty    <= 1'b1;
      full     <= 1'b0;
      overflow <= 1'b0;
      mode_r   <= SZ_SHALLOW;
    end else begin
      wr_ptr   <= wr_ptr_n;
      rd_ptr   <= rd_ptr_n;
      fill     <= fill_n;
      ofs_q    <= ofs_n;
      empty    <= (fill_n == '0);
      full     <= (fill_n == cap_n);
      overflow <= ovf_n;
      mode_r   <= fifo_size_e'(mode_n);
    end
  end
endmodule

// File: rtl/fifo_residual.sv
module fifo_residual #(
  parameter int OFS_W         = 10,
  parameter int SHALLOW_OFS_W = 7,
  parameter int LO_W          = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [OFS_W-1:0]      ofs_n,
  input  logic                  mode_n,
  input  logic [OFS_W-1:0]      bcnt,
  output logic [OFS_W-1:0]      residual,
  output logic [LO_W-1:0]       ofs_lo,
  output logic [OFS_W-LO_W-1:0] ofs_hi
);
  localparam logic [OFS_W-1:0] MASK_S = OFS_W'((1 << SHALLOW_OFS_W) - 1);

  logic [OFS_W-1:0] mask, ofs_m, diff;

  assign mask  = mode_n ? '1 : MASK_S;
  assign ofs_m = ofs_n & mask;
  assign diff  = (ofs_n - bcnt) & mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      residual <= '0;
      ofs_lo   <= '0;
      ofs_hi   <= '0;
    end else begin
      residual <= diff;
      ofs_lo   <= ofs_m[LO_W-1:0];
      ofs_hi   <= ofs_m[OFS_W-1:LO_W];
    end
  end
endmodule

// File: rtl/dma_byte_fifo.sv
module dma_byte_fifo
  import dma_fifo_pkg::*;
#(
  parameter int BYTE_W        = 8,
  parameter int SHALLOW_BYTES = 88,
  parameter int DEEP_BYTES    = 536,
  parameter int SHALLOW_OFS_W = 7,
  parameter int OFS_W         = 10,
  parameter int LO_W          = 8,
  localparam int PTR_W        = $clog2(DEEP_BYTES + 1),
  localparam int HI_W         = OFS_W - LO_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    deep_sel,
  input  logic                    wr_en,
  input  logic [LANES-1:0]        wr_be,
  input  logic [LANES*BYTE_W-1:0] wr_data,
  input  logic                    rd_en,
  output logic [BYTE_W-1:0]       rd_data,
  output logic                    rd_valid,
  input  logic [OFS_W-1:0]        bcnt,
  output logic [PTR_W-1:0]        fill,
  output logic                    empty,
  output logic                    full,
  output logic                    overflow,
  output logic [OFS_W-1:0]        residual,
  output logic [LO_W-1:0]         ofs_lo,
  output logic [HI_W-1:0]         ofs_hi
);
  localparam int LANE_W = $clog2(LANES);
  localparam int ROWS   = DEEP_BYTES / LANES;
  localparam int AW     = PTR_W - LANE_W;

  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [LANES-1:0]  lane_we;
  logic              rd_fire, mode_q, mode_n;
  logic [OFS_W-1:0]  ofs_n;
  logic [BYTE_W-1:0] lane_q [LANES];
  logic [LANE_W-1:0] rd_sel_q;

  fifo_ptr_ctrl #(
    .SHALLOW_BYTES(SHALLOW_BYTES),
    .DEEP_BYTES   (DEEP_BYTES),
    .PTR_W        (PTR_W),
    .OFS_W        (OFS_W)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .deep_sel(deep_sel),
    .wr_en   (wr_en),
    .wr_be   (wr_be),
    .rd_en   (rd_en),
    .wr_ptr  (wr_ptr),
    .rd_ptr  (rd_ptr),
    .lane_we (lane_we),
    .rd_fire (rd_fire),
    .fill    (fill),
    .empty   (empty),
    .full    (full),
    .overflow(overflow),
    .mode_q  (mode_q),
    .mode_n  (mode_n),
    .ofs_n   (ofs_n)
  );

  // One memory per byte lane. A write never crosses a row, so every lane uses the write row.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    byte_lane_ram #(
      .DEPTH(ROWS),
      .AW   (AW),
      .DW   (BYTE_W)
    ) u_ram (
      .clk  (clk),
      .we   (lane_we[l]),
      .waddr(wr_ptr[PTR_W-1:LANE_W]),
      .wdata(wr_data[l*BYTE_W +: BYTE_W]),
      .re   (rd_fire && (rd_ptr[LANE_W-1:0] == LANE_W'(l))),
      .raddr(rd_ptr[PTR_W-1:LANE_W]),
      .rdata(lane_q[l])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_sel_q <= '0;
    end else begin
      rd_valid <= rd_fire;
      if (rd_fire) rd_sel_q <= rd_ptr[LANE_W-1:0];
    end
  end

  assign rd_data = lane_q[rd_sel_q];

  fifo_residual #(
    .OFS_W        (OFS_W),
    .SHALLOW_OFS_W(SHALLOW_OFS_W),
    .LO_W         (LO_W)
  ) u_res (
    .clk     (clk),
    .rst     (rst),
    .ofs_n   (ofs_n),
    .mode_n  (mode_n),
    .bcnt    (bcnt),
    .residual(residual),
    .ofs_lo  (ofs_lo),
    .ofs_hi  (ofs_hi)
  );
endmodule

// File: rtl/dma_byte_fifo_chk.sv
module dma_byte_fifo_chk #(
  parameter int SHALLOW_BYTES = 88,
  parameter int DEEP_BYTES    = 536,
  parameter int PTR_W         = 10,
  parameter int HI_W          = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             clr,
  input logic             wr_en,
  input logic [3:0]       wr_be,
  input logic             rd_en,
  input logic             rd_valid,
  input logic [PTR_W-1:0] fill,
  input logic             empty,
  input logic             full,
  input logic             overflow,
  input logic [HI_W-1:0]  ofs_hi,
  input logic             mode_q
);
  // R1
  clear_state_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (fill == '0) && empty && !full && !overflow);

  // R1
  empty_flag_chk: assert property (@(posedge clk) disable iff (rst)
    empty == (fill == '0));

  // R4
  full_shallow_chk: assert property (@(posedge clk) disable iff (rst)
    (full && !mode_q) |-> (fill == PTR_W'(SHALLOW_BYTES)));

  // R5
  full_deep_chk: assert property (@(posedge clk) disable iff (rst)
    (full && mode_q) |-> (fill == PTR_W'(DEEP_BYTES)));

  // R6
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (overflow && !clr) |=> overflow);

  // R6
  full_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && (|wr_be) && !rd_en && !clr) |=> (overflow && (fill == $past(fill))));

  // R7
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_en) |=> !rd_valid);

  // R9
  shallow_hi_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_q |-> (ofs_hi == '0));
endmodule

bind dma_byte_fifo dma_byte_fifo_chk #(
  .SHALLOW_BYTES(SHALLOW_BYTES),
  .DEEP_BYTES   (DEEP_BYTES),
  .PTR_W        (PTR_W),
  .HI_W         (HI_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .clr     (clr),
  .wr_en   (wr_en),
  .wr_be   (wr_be),
  .rd_en   (rd_en),
  .rd_valid(rd_valid),
  .fill    (fill),
  .empty   (empty),
  .full    (full),
  .overflow(overflow),
  .ofs_hi  (ofs_hi),
  .mode_q  (mode_q)
);

// File: tb/dma_byte_fifo_test.sv
module dma_byte_fifo_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr = 1'b0;
  logic        deep_sel = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_be = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic [9:0]  bcnt = '0;
  logic [9:0]  fill;
  logic        empty, full, overflow;
  logic [9:0]  residual;
  logic [7:0]  ofs_lo;
  logic [1:0]  ofs_hi;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] q[$];
  int   cap_b = 88;
  int   ofs_b = 0;
  logic [7:0] gen = 8'h01;

  always #10 clk = ~clk;

  dma_byte_fifo uut (
    .clk(clk), .rst(rst), .clr(clr), .deep_sel(deep_sel),
    .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .bcnt(bcnt), .fill(fill), .empty(empty), .full(full),
    .overflow(overflow), .residual(residual), .ofs_lo(ofs_lo), .ofs_hi(ofs_hi)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    q.delete();
    ofs_b = 0;
  endtask

  task automatic push(input logic [3:0] be);
    int n = 0;
    logic [7:0] g = gen;
    logic [7:0] b[4];
    for (int l = 0; l < 4; l++) begin
      b[l] = g;
      g = g + 8'd1;
      if (be[l]) n++;
    end
    @(negedge clk);
    wr_en   = 1'b1;
    wr_be   = be;
    wr_data = {b[3], b[2], b[1], b[0]};
    if (q.size() + n <= cap_b) begin
      for (int l = 0; l < 4; l++) if (be[l]) q.push_back(b[l]);
      ofs_b += n;
      gen = g;
    end
    @(negedge clk);
    wr_en = 1'b0;
    wr_be = '0;
  endtask

  // One read; returns 1 when the observed byte matches the model.
  task automatic pop(output bit ok);
    logic [7:0] e;
    bit has = (q.size() > 0);
    if (has) e = q.pop_front();
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    ok = has ? (rd_valid === 1'b1 && rd_data === e) : (rd_valid === 1'b0);
    rd_en = 1'b0;
  endtask

  task automatic drain(input string req, input int n);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      bit ok;
      pop(ok);
      if (!ok) bad++;
    end
    check(req, "bytes out of order or missing", bad, 0);
  endtask

  task automatic t_reset();
    check("R1", "fill", fill, 0);
    check("R1", "empty", empty, 1);
    check("R1", "full", full, 0);
    check("R1", "overflow", overflow, 0);
    check("R1", "residual", residual, 0);
    check("R1", "ofs", {ofs_hi, ofs_lo}, 0);
    check("R1", "rd_valid", rd_valid, 0);
  endtask

  task automatic t_aligned();
    do_clear();
    for (int i = 0; i < 3; i++) push(4'b1111);
    check("R2", "fill after 3 dwords", fill, 12);
    drain("R2", 12);
    check("R2", "empty after drain", empty, 1);
  endtask

  task automatic t_misaligned();
    do_clear();
    push(4'b0001); push(4'b1110); push(4'b0111);
    push(4'b1000); push(4'b0011); push(4'b1100);
    check("R3", "fill after partial dwords", fill, 12);
    check("R9", "offset after partial dwords", ofs_lo, 12);
    drain("R3", 12);
  endtask

  task automatic t_shallow_full();
    do_clear();
    for (int i = 0; i < 22; i++) push(4'b1111);
    check("R4", "fill at shallow capacity", fill, 88);
    check("R4", "full", full, 1);
    push(4'b1111);
    check("R6", "fill after write when full", fill, 88);
    check("R6", "overflow set", overflow, 1);
    @(negedge clk); bcnt = 10'd10;
    @(negedge clk);
    check("R10", "shallow residual 88-10", residual, 78);
    bcnt = 10'd0;
    drain("R6", 88);
    check("R6", "overflow still set", overflow, 1);
  endtask

  task automatic t_partial_reject();
    do_clear();
    check("R1", "overflow cleared", overflow, 0);
    for (int i = 0; i < 22; i++) push(4'b1111);
    drain("R2", 2);
    check("R11", "fill after two reads", fill, 86);
    push(4'b1111);
    check("R6", "fill after oversize write", fill, 86);
    check("R6", "overflow on oversize write", overflow, 1);
    push(4'b0011);
    check("R6", "fill after fitting write", fill, 88);
    drain("R6", 86);
  endtask

  task automatic t_empty_read();
    bit ok;
    do_clear();
    pop(ok);
    check("R7", "rd_valid on empty read", rd_valid, 0);
    check("R7", "fill on empty read", fill, 0);
  endtask

  task automatic t_simultaneous();
    logic [7:0] e;
    do_clear();
    push(4'b1111); push(4'b1111);
    e = q.pop_front();
    @(negedge clk);
    wr_en = 1'b1; wr_be = 4'b1111; rd_en = 1'b1;
    wr_data = {gen + 8'd3, gen + 8'd2, gen + 8'd1, gen};
    for (int l = 0; l < 4; l++) q.push_back(gen + 8'(l));
    gen = gen + 8'd4;
    @(negedge clk);
    check("R2", "byte read alongside write", rd_data, e);
    check("R11", "fill after write and read", fill, 11);
    wr_en = 1'b0; wr_be = '0; rd_en = 1'b0;
    drain("R11", 11);
  endtask

  task automatic t_deep_and_switch();
    do_clear();
    @(negedge clk); deep_sel = 1'b1;
    idle(2);
    cap_b = 536;
    for (int i = 0; i < 134; i++) push(4'b1111);
    check("R5", "fill at deep capacity", fill, 536);
    check("R5", "full", full, 1);
    check("R9", "ofs_lo at 536", ofs_lo, 24);
    check("R9", "ofs_hi at 536", ofs_hi, 2);
    @(negedge clk);
    check("R10", "deep residual bcnt 0", residual, 536);
    bcnt = 10'd1000;
    @(negedge clk);
    check("R10", "deep residual with borrow", residual, 560);
    bcnt = 10'd0;
    deep_sel = 1'b0;
    idle(2);
    push(4'b1111);
    check("R8", "capacity kept while holding data", fill, 536);
    check("R8", "full kept while holding data", full, 1);
    drain("R5", 536);
    idle(2);
    cap_b = 88;
    for (int i = 0; i < 23; i++) push(4'b1111);
    check("R8", "shallow capacity after switch", fill, 88);
    check("R8", "full after switch", full, 1);
    drain("R8", 88);
  endtask

  task automatic t_shallow_wrap();
    do_clear();
    for (int i = 0; i < 22; i++) push(4'b1111);
    drain("R9", 88);
    for (int i = 0; i < 22; i++) push(4'b1111);
    check("R9", "ofs_lo wraps modulo 128", ofs_lo, 48);
    check("R9", "ofs_hi in shallow", ofs_hi, 0);
    @(negedge clk); bcnt = 10'd50;
    @(negedge clk);
    check("R10", "shallow residual after wrap", residual, 126);
    bcnt = 10'd0;
    @(negedge clk);
    check("R10", "shallow residual bcnt 0", residual, 48);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_aligned();
    t_misaligned();
    t_shallow_full();
    t_partial_reject();
    t_empty_read();
    t_simultaneous();
    t_deep_and_switch();
    t_shallow_wrap();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule